// File: doc/BRIEF.md
# Failover System Clock Controller

This block produces the system, peripheral and CPU clocks for a chip that has two high-frequency oscillators: an internal RC oscillator that is always running and an external crystal oscillator that may be missing or may stop. A software select bit picks the source that drives the system clock. The peripheral clock is always the system clock divided by two. A second select bit lets the CPU run either from the peripheral clock or from the full-rate system clock. The two bits give four clock modes.

The crystal is watched all the time it is selected. A counter clocked by the RC oscillator is cleared by every change of a toggle flop clocked by the crystal. If the counter reaches a programmable limit, the crystal is declared failed. Hardware then moves the system clock back to the RC oscillator and raises a non-maskable interrupt request. Both stay in place until software pulses the failure-clear input.

While flash is being programmed or erased, the CPU clock is held at the peripheral rate so that the flash timers stay accurate. Every change of clock path waits for the old path to close on its falling edge before the new path opens on its own falling edge. This keeps runt pulses off all three clock outputs. A status output reports the oscillator that actually drives the system clock.

Top module: `failover_clk_ctrl`

## Requirements
- R1: After reset the system clock comes from the RC oscillator, the CPU clock equals the peripheral clock, `src_is_xtal` is 0 and `nmi_req` is 0.
- R2: With no failure pending, `sys_sel_xtal` = 1 moves the system clock to the crystal and `sys_sel_xtal` = 0 moves it back to the RC oscillator.
- R3: `clk_per` runs at exactly half the rate of `clk_sys`, whichever source is active.
- R4: `cpu_sel_sys` = 1 makes `clk_cpu` follow `clk_sys`, and `cpu_sel_sys` = 0 makes it follow `clk_per`.
- R5: While `flash_busy` is 1, `clk_cpu` follows `clk_per` whatever the value of `cpu_sel_sys`. When `flash_busy` returns to 0, the CPU select bit applies again.
- R6: When the crystal is selected and shows no edge for TIMEOUT RC cycles, a failure is declared and the system clock returns to the RC oscillator without any software action. No failure is declared while fewer cycles than that have gone by.
- R7: `nmi_req` rises when a failure is declared and stays at 1 until `fail_clr` is pulsed.
- R8: After a failure, the crystal stays deselected even though `sys_sel_xtal` is still 1, and even if the crystal starts again, until `fail_clr` is pulsed. After the clear, the crystal is selected again.
- R9: No high or low pulse on `clk_sys` or `clk_cpu` is shorter than the shorter half-period of the two oscillators. At most one source path and at most one CPU path is open at any time.
- R10: `src_is_xtal` is 1 only after the crystal path is open and the RC path is closed. It is 0 whenever the RC oscillator drives the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC oscillator clock, always running |
| clk_xtal | input | 1 | Crystal oscillator clock, may stop |
| rst | input | 1 | Synchronous active-high reset, in the RC clock domain |
| sys_sel_xtal | input | 1 | System source select: 0 RC, 1 crystal |
| cpu_sel_sys | input | 1 | CPU clock select: 0 peripheral clock, 1 system clock |
| flash_busy | input | 1 | Flash program or erase in progress |
| fail_clr | input | 1 | Clears a latched crystal failure (pulse) |
| clk_sys | output | 1 | System clock |
| clk_per | output | 1 | Peripheral clock, system clock divided by two |
| clk_cpu | output | 1 | CPU clock |
| src_is_xtal | output | 1 | 1 when the crystal drives the system clock |
| nmi_req | output | 1 | Non-maskable interrupt request on crystal failure |

## Verification
The bench builds the block with TIMEOUT = 16 and two synchronizer stages. A stopped crystal is therefore declared failed about twenty RC cycles after its last edge. This brings the point just before the limit and the point just after it within a short run. The RC clock runs at 50 MHz and the crystal at about 71 MHz, so edge counts over a fixed window tell the two sources apart and show the divide-by-two. A pulse-width monitor runs across every source change, CPU-path change and failover, and checks that no runt pulse appears.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic {
    SRC_RC   = 1'b0,
    SRC_XTAL = 1'b1
  } clk_src_e;
endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkctl_xtal_monitor.sv
module clkctl_xtal_monitor #(
  parameter int TIMEOUT     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_rc,
  input  logic clk_xtal,
  input  logic rst,
  input  logic x_rst,
  input  logic arm,
  input  logic clr,
  output logic fail
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic             tog;
  logic             tog_s;
  logic             tog_d;
  logic             seen;
  logic [CNT_W-1:0] cnt;

  // crystal-domain heartbeat
  always_ff @(posedge clk_xtal) begin
    if (x_rst) tog <= 1'b0;
    else       tog <= ~tog;
  end

  clkctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tog_sync (
    .clk(clk_rc), .d(tog), .q(tog_s)
  );

  always_ff @(posedge clk_rc) begin
    if (rst) tog_d <= 1'b0;
    else     tog_d <= tog_s;
  end

  assign seen = tog_s ^ tog_d;

  always_ff @(posedge clk_rc) begin
    if (rst || clr || !arm)  cnt <= '0;
    else if (seen)           cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk_rc) begin
    if (rst || clr)                         fail <= 1'b0;
    else if (arm && !seen && cnt == LIMIT)  fail <= 1'b1;
  end
endmodule

// File: rtl/clkctl_src_mux.sv
module clkctl_src_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_rc,
  input  logic clk_xtal,
  input  logic rst,
  input  logic x_rst,
  input  logic sel_xtal,
  input  logic force_rc,
  output logic clk_out,
  output logic rc_en,
  output logic x_en,
  output logic x_en_rc
);
  logic rc_arm;
  logic [1:0] to_x;
  logic       x_req;
  logic       rc_en_x;

  // RC side: open only once the crystal path is seen closed (or the crystal is dead)
  clkctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_xen_sync (
    .clk(clk_rc), .d(x_en), .q(x_en_rc)
  );

  assign rc_arm = ~sel_xtal & (~x_en_rc | force_rc);

  always_ff @(negedge clk_rc) begin
    if (rst) rc_en <= 1'b1;
    else     rc_en <= rc_arm;
  end

  // crystal side: open only once the RC path is seen closed
  clkctl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_x_sync (
    .clk(clk_xtal), .d({sel_xtal, rc_en}), .q(to_x)
  );

  assign x_req   = to_x[1];
  assign rc_en_x = to_x[0];

  always_ff @(negedge clk_xtal) begin
    if (x_rst) x_en <= 1'b0;
    else       x_en <= x_req & ~rc_en_x;
  end

  assign clk_out = (clk_rc & rc_en) | (clk_xtal & x_en & ~force_rc);
endmodule

// File: rtl/clkctl_cpu_clk.sv
module clkctl_cpu_clk #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_sys,
  input  logic rst,
  input  logic cpu_sel_sys,
  input  logic flash_busy,
  output logic clk_per,
  output logic clk_cpu,
  output logic sys_en,
  output logic per_en,
  output logic flash_s
);
  logic [2:0] in_s;
  logic       rst_s;
  logic       sel_s;
  logic       want_sys;

  clkctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk_sys), .d({rst, cpu_sel_sys, flash_busy}), .q(in_s)
  );

  assign rst_s    = in_s[2];
  assign sel_s    = in_s[1];
  assign flash_s  = in_s[0];
  assign want_sys = sel_s & ~flash_s;

  always_ff @(posedge clk_sys) begin
    if (rst_s) clk_per <= 1'b0;
    else       clk_per <= ~clk_per;
  end

  // full-rate path: close at any falling edge, open after the half-rate path is closed
  always_ff @(negedge clk_sys) begin
    if (rst_s)         sys_en <= 1'b0;
    else if (!want_sys) sys_en <= 1'b0;
    else if (!per_en)   sys_en <= 1'b1;
  end

  // half-rate path: change only while the divided clock is low
  always_ff @(negedge clk_sys) begin
    if (rst_s)              per_en <= 1'b1;
    else if (!clk_per) begin
      if (want_sys)         per_en <= 1'b0;
      else if (!sys_en)     per_en <= 1'b1;
    end
  end

  assign clk_cpu = (clk_sys & sys_en) | (clk_per & per_en);
endmodule

// File: rtl/failover_clk_ctrl.sv
module failover_clk_ctrl
  import clkctl_pkg::*;
#(
  parameter int TIMEOUT     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_rc,
  input  logic clk_xtal,
  input  logic rst,
  input  logic sys_sel_xtal,
  input  logic cpu_sel_sys,
  input  logic flash_busy,
  input  logic fail_clr,
  output logic clk_sys,
  output logic clk_per,
  output logic clk_cpu,
  output logic src_is_xtal,
  output logic nmi_req
);
  logic [1:0] sw_s;
  logic       sel_s;
  logic       clr_s;
  logic       x_rst;
  logic       fail;
  logic       eff_sel;
  logic       src_rc_en;
  logic       src_x_en;
  logic       x_en_rc;
  logic       cpu_sys_en;
  logic       cpu_per_en;
  logic       flash_s;
  clk_src_e   active_src;

  clkctl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sw_sync (
    .clk(clk_rc), .d({sys_sel_xtal, fail_clr}), .q(sw_s)
  );
  assign sel_s = sw_s[1];
  assign clr_s = sw_s[0];

  clkctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_xrst_sync (
    .clk(clk_xtal), .d(rst), .q(x_rst)
  );

  clkctl_xtal_monitor #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_rc(clk_rc), .clk_xtal(clk_xtal), .rst(rst), .x_rst(x_rst),
    .arm(sel_s), .clr(clr_s), .fail(fail)
  );

  always_ff @(posedge clk_rc) begin
    if (rst) eff_sel <= 1'b0;
    else     eff_sel <= sel_s & ~fail;
  end

  clkctl_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_rc(clk_rc), .clk_xtal(clk_xtal), .rst(rst), .x_rst(x_rst),
    .sel_xtal(eff_sel), .force_rc(fail), .clk_out(clk_sys),
    .rc_en(src_rc_en), .x_en(src_x_en), .x_en_rc(x_en_rc)
  );

  always_ff @(posedge clk_rc) begin
    if (rst)                  active_src <= SRC_RC;
    else if (x_en_rc && !fail) active_src <= SRC_XTAL;
    else                      active_src <= SRC_RC;
  end

  assign src_is_xtal = (active_src == SRC_XTAL);
  assign nmi_req     = fail;

  clkctl_cpu_clk #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .clk_sys(clk_sys), .rst(rst), .cpu_sel_sys(cpu_sel_sys),
    .flash_busy(flash_busy), .clk_per(clk_per), .clk_cpu(clk_cpu),
    .sys_en(cpu_sys_en), .per_en(cpu_per_en), .flash_s(flash_s)
  );
endmodule

// File: rtl/clkctl_checker.sv
module clkctl_checker (
  input logic clk_rc,
  input logic clk_sys,
  input logic rst,
  input logic rc_en,
  input logic x_en,
  input logic nmi_req,
  input logic clr_s,
  input logic src_is_xtal,
  input logic sys_en,
  input logic per_en,
  input logic flash_s
);
  AST_SRC_EXCLUSIVE: assert property (@(posedge clk_rc) disable iff (rst)
    !(rc_en && x_en && !nmi_req)); // R9

  AST_NMI_HOLD: assert property (@(posedge clk_rc) disable iff (rst)
    (nmi_req && !clr_s) |=> nmi_req); // R7

  AST_FAIL_DROPS_STATUS: assert property (@(posedge clk_rc) disable iff (rst)
    nmi_req |=> !src_is_xtal); // R8

  AST_STATUS_AFTER_SWITCH: assert property (@(posedge clk_rc) disable iff (rst)
    $rose(src_is_xtal) |-> !rc_en); // R10

  AST_CPU_EXCLUSIVE: assert property (@(posedge clk_sys) disable iff (rst)
    !(sys_en && per_en)); // R9

  AST_FLASH_FORCE: assert property (@(posedge clk_sys) disable iff (rst)
    (flash_s && $past(flash_s)) |-> !sys_en); // R5
endmodule

bind failover_clk_ctrl clkctl_checker u_chk (
  .clk_rc(clk_rc), .clk_sys(clk_sys), .rst(rst),
  .rc_en(src_rc_en), .x_en(src_x_en), .nmi_req(nmi_req), .clr_s(clr_s),
  .src_is_xtal(src_is_xtal), .sys_en(cpu_sys_en), .per_en(cpu_per_en),
  .flash_s(flash_s)
);

// File: tb/tb_failover_clk_ctrl.sv
`timescale 1ns/1ps
module tb_failover_clk_ctrl;
  logic clk_rc = 1'b0;
  logic clk_xtal = 1'b0;
  logic xrun = 1'b1;
  logic rst = 1'b1;
  logic sys_sel_xtal = 1'b0;
  logic cpu_sel_sys = 1'b0;
  logic flash_busy = 1'b0;
  logic fail_clr = 1'b0;
  logic clk_sys, clk_per, clk_cpu, src_is_xtal, nmi_req;

  int total = 0;
  int bad = 0;
  int n_sys = 0, n_per = 0, n_cpu = 0;
  realtime t_sys = 0.0, t_cpu = 0.0;
  realtime min_sys = 1000.0, min_cpu = 1000.0;
  bit mon_on = 1'b0;

  failover_clk_ctrl #(.TIMEOUT(16), .SYNC_STAGES(2)) dut (
    .clk_rc(clk_rc), .clk_xtal(clk_xtal), .rst(rst),
    .sys_sel_xtal(sys_sel_xtal), .cpu_sel_sys(cpu_sel_sys),
    .flash_busy(flash_busy), .fail_clr(fail_clr),
    .clk_sys(clk_sys), .clk_per(clk_per), .clk_cpu(clk_cpu),
    .src_is_xtal(src_is_xtal), .nmi_req(nmi_req)
  );

  always #10 clk_rc = ~clk_rc;
  initial forever begin
    #7;
    if (xrun) clk_xtal = ~clk_xtal;
  end

  always @(posedge clk_sys) n_sys++;
  always @(posedge clk_per) n_per++;
  always @(posedge clk_cpu) n_cpu++;

  always @(clk_sys) begin
    if (mon_on && ($realtime - t_sys) < min_sys) min_sys = $realtime - t_sys;
    t_sys = $realtime;
  end
  always @(clk_cpu) begin
    if (mon_on && ($realtime - t_cpu) < min_cpu) min_cpu = $realtime - t_cpu;
    t_cpu = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic near(input string req, input string what, input int act,
                      input int exp, input int tol);
    chk((act >= exp - tol) && (act <= exp + tol), req, what, act, exp);
  endtask

  task automatic wait_rc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_rc);
    #3;
  endtask

  // 1400 ns window: RC gives 70 system edges, crystal gives 100
  task automatic measure(output int s, output int p, output int c);
    int s0, p0, c0;
    s0 = n_sys; p0 = n_per; c0 = n_cpu;
    #1400;
    s = n_sys - s0; p = n_per - p0; c = n_cpu - c0;
  endtask

  task automatic t_reset();
    int s, p, c;
    rst = 1'b1; wait_rc(6); rst = 1'b0; wait_rc(20);
    mon_on = 1'b1;
    chk(src_is_xtal == 1'b0, "R1", "src_is_xtal after reset", src_is_xtal, 0);
    chk(nmi_req == 1'b0, "R1", "nmi_req after reset", nmi_req, 0);
    measure(s, p, c);
    near("R1", "sys edges on RC", s, 70, 2);
    near("R1", "cpu edges equal per edges", c, p, 1);
    near("R3", "per edges half of sys on RC", p * 2, s, 2);
  endtask

  task automatic t_select_xtal();
    int s, p, c;
    sys_sel_xtal = 1'b1; wait_rc(50);
    chk(src_is_xtal == 1'b1, "R10", "status after move to crystal", src_is_xtal, 1);
    measure(s, p, c);
    near("R2", "sys edges on crystal", s, 100, 2);
    near("R3", "per edges half of sys on crystal", p * 2, s, 2);
  endtask

  task automatic t_cpu_modes();
    int s, p, c;
    cpu_sel_sys = 1'b1; wait_rc(20);
    measure(s, p, c);
    near("R4", "cpu follows sys", c, s, 1);
    flash_busy = 1'b1; wait_rc(20);
    measure(s, p, c);
    near("R5", "cpu forced to per during flash", c, p, 1);
    flash_busy = 1'b0; wait_rc(20);
    measure(s, p, c);
    near("R5", "cpu back to sys after flash", c, s, 1);
    cpu_sel_sys = 1'b0; wait_rc(20);
    measure(s, p, c);
    near("R4", "cpu follows per", c, p, 1);
  endtask

  task automatic t_failover();
    int s, p, c;
    @(negedge clk_xtal); xrun = 1'b0;
    wait_rc(8);
    chk(nmi_req == 1'b0, "R6", "no failure before timeout", nmi_req, 0);
    wait_rc(40);
    chk(nmi_req == 1'b1, "R7", "nmi raised after timeout", nmi_req, 1);
    chk(src_is_xtal == 1'b0, "R6", "status back on RC", src_is_xtal, 0);
    measure(s, p, c);
    near("R6", "sys edges on RC after failover", s, 70, 2);
  endtask

  task automatic t_hold_and_clear();
    int s, p, c;
    xrun = 1'b1; wait_rc(60);
    chk(nmi_req == 1'b1, "R7", "nmi held before clear", nmi_req, 1);
    chk(src_is_xtal == 1'b0, "R8", "crystal still deselected", src_is_xtal, 0);
    measure(s, p, c);
    near("R8", "sys stays on RC with crystal back", s, 70, 2);
    fail_clr = 1'b1; wait_rc(4); fail_clr = 1'b0; wait_rc(50);
    chk(nmi_req == 1'b0, "R7", "nmi cleared", nmi_req, 0);
    chk(src_is_xtal == 1'b1, "R8", "crystal reselected after clear", src_is_xtal, 1);
    measure(s, p, c);
    near("R8", "sys on crystal after clear", s, 100, 2);
  endtask

  task automatic t_back_to_rc();
    int s, p, c;
    sys_sel_xtal = 1'b0; wait_rc(50);
    chk(src_is_xtal == 1'b0, "R2", "status after move to RC", src_is_xtal, 0);
    measure(s, p, c);
    near("R2", "sys edges back on RC", s, 70, 2);
  endtask

  task automatic t_pulses();
    chk(min_sys >= 6.5, "R9", "shortest sys phase ps", int'(min_sys * 1000.0), 7000);
    chk(min_cpu >= 6.5, "R9", "shortest cpu phase ps", int'(min_cpu * 1000.0), 7000);
  endtask

  initial begin
    t_reset();
    t_select_xtal();
    t_cpu_modes();
    t_failover();
    t_hold_and_clear();
    t_back_to_rc();
    t_pulses();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule